// File: doc/BRIEF.md
# Microsecond Tick Timer with Compare

This block keeps a 64-bit free-running time base that steps by one on every cycle where a 1 MHz strobe is high and counting is enabled. Software reaches the count, a 64-bit compare value, a small control word and a status word through a simple register bus of 32-bit words. The bus has separate read and write strobes and a 3-bit word address.

A compare event occurs on a counting step where the current count equals the compare value. Each event raises a level interrupt and adds one to a 4-bit event counter. That counter sticks at its maximum. In clear-on-compare mode the event step reloads zero instead of stepping on, so the timer becomes a periodic divider. The interrupt stays high until the host pulses the acknowledge input.

Reading the low count word captures the high word at the same instant. A following high-word read therefore pairs with the low word already read, even if the count carries in between.

Top module: `usec_timer`

## Requirements
- R1: After reset the count, compare value, control word and event counter are all zero, and `irq` is low.
- R2: With control bit 0 (enable) set, the count rises by exactly one on each cycle that `tick_1us` is high. The carry passes from the low word into the high word, and the count wraps from all ones to zero. With enable clear, or with `tick_1us` low, the count holds.
- R3: Word addresses are: 0 count low, 1 count high, 2 compare low, 3 compare high, 4 control (bit 0 enable, bit 1 clear-on-compare), 5 status (bits 3:0 event counter). `bus_rdata` is registered: it shows the addressed word in the cycle after `bus_rd` is high and holds until the next read.
- R4: A compare event is a cycle with `tick_1us` high, enable set and count equal to the compare value. `irq` is high in the cycle after an event.
- R5: Once high, `irq` stays high until a cycle with `irq_ack` high, which clears it. A compare event in that same cycle keeps it high.
- R6: Each compare event adds one to the 4-bit event counter, which stays at 15 once it gets there.
- R7: With control bit 1 set, a compare event loads zero into the count instead of stepping it. With bit 1 clear, the count steps past the compare value.
- R8: A write to a count word replaces that word and wins over a step in the same cycle. The other word keeps its current value.
- R9: A read of address 1 returns the high word as it stood at the last read of address 0.
- R10: Writes to the status address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | One-cycle strobe at 1 MHz |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Level interrupt |

## Verification
Assertions check the following on every cycle:
- single steps, holding while idle, and the reload to zero;
- a write winning over a step;
- the interrupt being set by an event and held until acknowledge;
- the event counter only moving on an event and sticking at 15;
- read data holding between reads.

Some behaviour only the bench scenarios can show: carries across the word boundary, the full wrap, coherent high-word snapshots across a carry, the register map decode, and the status word ignoring writes.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_CMP_LO = 3'd2,
    A_CMP_HI = 3'd3,
    A_CTRL   = 3'd4,
    A_STAT   = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic clr_on_match;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/usec_count_core.sv
module usec_count_core #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32,
  localparam int NW    = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              clr_on_match,
  input  logic              match,
  input  logic [NW-1:0]     wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] adv;
  logic [CNT_W-1:0] cnt_d;
  logic             wr_any;

  assign wr_any = |wr_en;

  always_comb begin
    adv = count;
    if (tick && enable) begin
      if (match && clr_on_match) adv = '0;
      else                       adv = count + 1'b1;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_lane
    assign cnt_d[g*WORD_W +: WORD_W] =
      wr_en[g] ? wr_data :
      (wr_any ? count[g*WORD_W +: WORD_W] : adv[g*WORD_W +: WORD_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end

  // R2: single step
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && !match && wr_en == '0) |=> count == $past(count) + 1'b1);
  // R2: hold when not counting
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && enable) && wr_en == '0) |=> $stable(count));
  // R7: reload to zero on event
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && match && clr_on_match && wr_en == '0) |=> count == '0);
  // R8: write wins
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> count[WORD_W-1:0] == $past(wr_data));
endmodule

// File: rtl/usec_match_unit.sv
module usec_match_unit #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32,
  parameter int OVF_W  = 4,
  localparam int NW    = CNT_W / WORD_W,
  localparam logic [OVF_W-1:0] OVF_MAX = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic [CNT_W-1:0]  count,
  input  logic [NW-1:0]     cmp_wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              irq_ack,
  output logic [CNT_W-1:0]  cmp,
  output logic              match,
  output logic              irq,
  output logic [OVF_W-1:0]  ovf
);
  assign match = tick && enable && (count == cmp);

  for (genvar g = 0; g < NW; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)            cmp[g*WORD_W +: WORD_W] <= '0;
      else if (cmp_wr_en[g]) cmp[g*WORD_W +: WORD_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      ovf <= '0;
    end else begin
      if (match)        irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
      if (match && ovf != OVF_MAX) ovf <= ovf + 1'b1;
    end
  end

  // R4: event raises irq
  a_r4_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq);
  // R5: irq held until acknowledged
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
  // R6: counter moves only on events
  a_r6_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(ovf));
  // R6: saturation
  a_r6_ovf_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf == OVF_MAX) |=> ovf == OVF_MAX);
endmodule

// File: rtl/usec_reg_bank.sv
module usec_reg_bank
  import usec_timer_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32,
  parameter int OVF_W  = 4,
  localparam int NW    = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [OVF_W-1:0]  ovf,
  output logic [NW-1:0]     cnt_wr_en,
  output logic [NW-1:0]     cmp_wr_en,
  output ctrl_t             ctrl,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam int CNT_BASE = int'(A_CNT_LO);
  localparam int CMP_BASE = int'(A_CMP_LO);

  logic [CNT_W-WORD_W-1:0] hi_snap;
  logic [WORD_W-1:0]       rd_mux;

  for (genvar g = 0; g < NW; g++) begin : g_dec
    assign cnt_wr_en[g] = bus_wr && (bus_addr == ADDR_W'(CNT_BASE + g));
    assign cmp_wr_en[g] = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          ctrl <= '0;
    else if (bus_wr && bus_addr == A_CTRL) ctrl <= ctrl_t'(bus_wdata[1:0]);
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CNT_LO: rd_mux = count[WORD_W-1:0];
      A_CNT_HI: rd_mux = hi_snap[WORD_W-1:0];
      A_CMP_LO: rd_mux = cmp[WORD_W-1:0];
      A_CMP_HI: rd_mux = cmp[2*WORD_W-1:WORD_W];
      A_CTRL:   rd_mux = {{(WORD_W-2){1'b0}}, ctrl};
      A_STAT:   rd_mux = {{(WORD_W-OVF_W){1'b0}}, ovf};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      hi_snap   <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
      if (bus_addr == A_CNT_LO) hi_snap <= count[CNT_W-1:WORD_W];
    end
  end

  // R3: read data holds between reads
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R9: snapshot changes only on a low-word read
  a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == A_CNT_LO) |=> $stable(hi_snap));
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_timer_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32,
  parameter int OVF_W  = 4,
  localparam int NW    = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmp;
  logic [OVF_W-1:0] ovf;
  logic [NW-1:0]    cnt_wr_en;
  logic [NW-1:0]    cmp_wr_en;
  logic             match;
  ctrl_t            ctrl;

  usec_reg_bank #(.CNT_W(CNT_W), .WORD_W(WORD_W), .OVF_W(OVF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count), .cmp(cmp),
    .ovf(ovf), .cnt_wr_en(cnt_wr_en), .cmp_wr_en(cmp_wr_en), .ctrl(ctrl),
    .bus_rdata(bus_rdata)
  );

  usec_count_core #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .enable(ctrl.enable),
    .clr_on_match(ctrl.clr_on_match), .match(match), .wr_en(cnt_wr_en),
    .wr_data(bus_wdata), .count(count)
  );

  usec_match_unit #(.CNT_W(CNT_W), .WORD_W(WORD_W), .OVF_W(OVF_W)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .enable(ctrl.enable),
    .count(count), .cmp_wr_en(cmp_wr_en), .wr_data(bus_wdata),
    .irq_ack(irq_ack), .cmp(cmp), .match(match), .irq(irq), .ovf(ovf)
  );

  // R1: irq low on the first cycle after reset
  a_r1_irq_reset: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/usec_timer_test.sv
module usec_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_ack = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usec_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq(irq)
  );

  // {count_lo, count_hi, ticks, exp_lo, exp_hi}
  localparam logic [159:0] VEC [0:3] = '{
    {32'h0000_0000, 32'h0000_0000, 32'd3, 32'h0000_0003, 32'h0000_0000},
    {32'hFFFF_FFFE, 32'h0000_0000, 32'd3, 32'h0000_0001, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'h0000_0000, 32'h0000_0000},
    {32'h0000_1234, 32'h0000_0055, 32'd7, 32'h0000_123B, 32'h0000_0055}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1us = 1'b1;
      @(negedge clk); tick_1us = 1'b0;
    end
  endtask

  task automatic ack;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 R3 addr%0d", a), v, 32'd0);
    end

    // R2: table of counting patterns, compare parked far away
    wr(3'd3, 32'h0000_0100);
    wr(3'd2, 32'h0);
    wr(3'd4, 32'h1);
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, VEC[k][159:128]);
      wr(3'd1, VEC[k][127:96]);
      ticks(int'(VEC[k][95:64]));
      rd(3'd0, v); chk($sformatf("R2 vec%0d lo", k), v, VEC[k][63:32]);
      rd(3'd1, v); chk($sformatf("R2 vec%0d hi", k), v, VEC[k][31:0]);
    end

    // R2: disabled, no step
    wr(3'd4, 32'h0);
    wr(3'd0, 32'd40);
    ticks(5);
    rd(3'd0, v); chk("R2 disabled hold", v, 32'd40);
    rd(3'd4, v); chk("R3 ctrl readback", v, 32'd0);

    // R4 R6 R7: event in normal mode steps past compare
    wr(3'd3, 32'h0); wr(3'd2, 32'd10);
    wr(3'd1, 32'h0); wr(3'd0, 32'd8);
    wr(3'd4, 32'h1);
    ticks(2);
    chk("R4 no irq before event", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R4 irq after event", {31'd0, irq}, 32'd1);
    rd(3'd0, v); chk("R7 normal mode steps past", v, 32'd11);
    rd(3'd5, v); chk("R6 one event", v, 32'd1);
    rd(3'd2, v); chk("R3 compare low readback", v, 32'd10);

    // R5: held until acknowledged
    repeat (4) @(negedge clk);
    chk("R5 irq held", {31'd0, irq}, 32'd1);
    ack();
    chk("R5 irq cleared by ack", {31'd0, irq}, 32'd0);

    // R7: clear-on-compare reload
    wr(3'd4, 32'h3);
    wr(3'd2, 32'd5); wr(3'd0, 32'd5);
    ticks(1);
    rd(3'd0, v); chk("R7 reload to zero", v, 32'd0);
    rd(3'd5, v); chk("R6 two events", v, 32'd2);
    ack();

    // R6: saturation with compare zero, every step is an event
    wr(3'd2, 32'd0);
    ticks(20);
    rd(3'd5, v); chk("R6 saturate", v, 32'd15);
    rd(3'd0, v); chk("R7 stays zero", v, 32'd0);

    // R10: status ignores writes
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R10 status unchanged", v, 32'd15);
    ack();

    // R8: write in a step cycle wins
    wr(3'd4, 32'h1);
    wr(3'd3, 32'h0000_0100);
    wr(3'd1, 32'h0);
    @(negedge clk);
    tick_1us = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h55;
    @(negedge clk);
    tick_1us = 1'b0; bus_wr = 1'b0;
    rd(3'd0, v); chk("R8 write wins lo", v, 32'h55);
    rd(3'd1, v); chk("R8 other word kept", v, 32'h0);

    // R9: coherent high word across a carry
    wr(3'd1, 32'd7); wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R9 lo before carry", v, 32'hFFFF_FFFF);
    ticks(1);
    rd(3'd1, v); chk("R9 hi snapshot", v, 32'd7);
    rd(3'd0, v); chk("R9 lo after carry", v, 32'd0);
    rd(3'd1, v); chk("R9 hi fresh", v, 32'd8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule